// File: doc/BRIEF.md
# Oversampling Baud Tick Generator

This block turns a fixed system clock into the two timing strobes a serial port needs. A phase accumulator adds a programmed increment on every enabled clock cycle. Each time the sum wraps past the top of the accumulator, the block emits one pulse of the oversample strobe, which a receiver uses to sample its line at sixteen times the bit rate. A counter then divides that strobe by the oversample ratio to give the bit strobe. The transmitter uses the bit strobe to shift out one bit, and any bit-time counters (such as a receive idle timeout) use it as their time base.

The increment sets the rate. For a 16-bit accumulator and 16x oversampling, the increment is 2^20 · baud / f_clk. A fractional rate is therefore built from an integer step with no divider chain, and the error spreads evenly over the cycles instead of piling up. Holding the enable low, or writing an increment of zero, parks the whole generator at phase zero. The next start then behaves exactly like the first start after reset.

Top module: `baud_nco`

## Requirements
- R1: While reset is high, and on the first cycle after it, both `tick16_o` and `bit_tick_o` are low.
- R2: Count k as the k-th rising clock edge at which `en_i` is high and `inc_i` is nonzero, counting from the start of a run. `tick16_o` is high in the cycle that follows edge k exactly when floor(k·inc/2^16) > floor((k-1)·inc/2^16), i.e. when the 16-bit addition at that edge carries out.
- R3: `bit_tick_o` is high in the cycle after the cycle in which the 16th, 32nd, 48th, … `tick16_o` pulse of the run was high, and at no other time.
- R4: `bit_tick_o` is never high on two consecutive cycles.
- R5: A clock edge with `en_i` low clears the accumulator and the divide counter. Both outputs are low in the following cycle. A later run restarts its counting at k = 1.
- R6: An increment of zero acts like a low enable: the outputs stay low and the phase is held at zero. When a nonzero increment is applied afterwards, counting restarts at k = 1 with no leftover phase.
- R7: After the start of a run, `bit_tick_o` does not rise before sixteen `tick16_o` pulses have been produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low holds the generator at phase zero |
| inc_i | input | 16 | Phase increment, 2^20·baud/f_clk |
| tick16_o | output | 1 | One-cycle strobe at 16x the bit rate |
| bit_tick_o | output | 1 | One-cycle strobe once per bit time |

## Verification
A corrupted accumulator phase shows up at the ports as a shifted `tick16_o` pattern. Against the exact floor-division schedule, the error appears on the first pulse that lands one cycle early or late, which for large increments is within a few cycles. A wrong divide count shows up at the 16th oversample pulse, when `bit_tick_o` comes early, late or is missing. Phase left over from an earlier run, after a disable or a zero increment, is exposed on the first pulse of the next run, because the bench always expects that run to start from phase zero.

// File: rtl/baud_nco_pkg.sv
package baud_nco_pkg;
  // Default geometry of the generator
  parameter int unsigned DEF_ACC_W = 16;
  parameter int unsigned DEF_OVS   = 16;

  // Width needed to count 0 .. n-1 (at least one bit)
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/baud_nco_acc.sv
module baud_nco_acc #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, inc_i};

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      tick_o <= sum[ACC_W];
    end
  end

  // R2
  wrap_tick_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (acc_q < $past(acc_q)));
endmodule

// File: rtl/baud_nco_div.sv
module baud_nco_div #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic tick_i,
  output logic bit_o
);
  import baud_nco_pkg::*;
  localparam int unsigned CW = cnt_width(OVS);

  generate
    if (OVS == 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst || !run_i) bit_o <= 1'b0;
        else               bit_o <= tick_i;
      end
    end else begin : g_cnt
      localparam logic [CW-1:0] LAST = CW'(OVS - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || !run_i) begin
          cnt_q <= '0;
          bit_o <= 1'b0;
        end else begin
          bit_o <= tick_i && (cnt_q == LAST);
          if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end

      // R4
      bit_single_chk: assert property (@(posedge clk) disable iff (rst)
        bit_o |=> !bit_o);
    end
  endgenerate
endmodule

// File: rtl/baud_nco.sv
module baud_nco #(
  parameter int unsigned ACC_W = baud_nco_pkg::DEF_ACC_W,
  parameter int unsigned OVS   = baud_nco_pkg::DEF_OVS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic             tick16_o,
  output logic             bit_tick_o
);
  logic run;
  logic t16;
  logic tbit;

  assign run = en_i && (inc_i != '0);

  baud_nco_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .run_i(run), .inc_i(inc_i), .tick_o(t16)
  );

  baud_nco_div #(.OVS(OVS)) u_div (
    .clk(clk), .rst(rst), .run_i(run), .tick_i(t16), .bit_o(tbit)
  );

  assign tick16_o   = t16;
  assign bit_tick_o = tbit;

  // R3
  bit_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    bit_tick_o |-> $past(tick16_o));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!tick16_o && !bit_tick_o));
endmodule

// File: tb/baud_nco_tb.sv
module baud_nco_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [15:0] inc = '0;
  logic        t16, tbit;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  baud_nco u_dut (
    .clk(clk), .rst(rst), .en_i(en), .inc_i(inc),
    .tick16_o(t16), .bit_tick_o(tbit)
  );

  function automatic longint unsigned wraps(input longint unsigned k, input longint unsigned s);
    return (k * s) >> 16;
  endfunction

  function automatic bit carry_at(input longint unsigned k, input longint unsigned s);
    if (k == 0) return 1'b0;
    return wraps(k, s) != wraps(k - 1, s);
  endfunction

  task automatic chk(input string req, input logic got, input logic exp, input longint unsigned k);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s k=%0d inc=%h got=%0b exp=%0b", req, k, inc, got, exp);
    end
  endtask

  task automatic run_case(input logic [15:0] s, input int ncyc, input bit keep_en);
    logic prev_bit;
    prev_bit = 1'b0;
    @(negedge clk);
    inc = s;
    en  = 1'b1;
    for (int k = 1; k <= ncyc; k++) begin
      bit e16, ebit;
      @(negedge clk);
      e16  = carry_at(k, s);
      ebit = (k >= 2) && carry_at(k - 1, s) && (wraps(k - 1, s) % 16 == 0);
      chk("R2", t16, e16, k);
      chk("R3", tbit, ebit, k);
      // R7: no bit strobe before sixteen oversample pulses
      if (wraps(k - 1, s) < 16) chk("R7", tbit, 1'b0, k);
      // R4: bit strobe is one cycle wide
      if (prev_bit) chk("R4", tbit, 1'b0, k);
      prev_bit = tbit;
    end
    if (!keep_en) begin
      en = 1'b0;
      @(negedge clk);
      chk("R5", t16, 1'b0, 0);
      chk("R5", tbit, 1'b0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", t16, 1'b0, 0);
    chk("R1", tbit, 1'b0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", t16, 1'b0, 0);
    chk("R1", tbit, 1'b0, 0);

    run_case(16'h0001, 2000, 1'b0);
    run_case(16'h1000, 3000, 1'b0);
    run_case(16'h0C49, 3000, 1'b0);
    run_case(16'h5555, 3000, 1'b0);
    run_case(16'h8000, 2000, 1'b0);
    run_case(16'h7FFF, 2000, 1'b0);
    run_case(16'hFFFF, 2000, 1'b0);
    run_case(16'h0101, 3000, 1'b0);

    // R5: short run, disable part way, then restart from phase zero
    run_case(16'h3333, 37, 1'b0);
    run_case(16'h3333, 1000, 1'b0);

    // R6: enable high with a zero increment keeps outputs low
    @(negedge clk);
    en  = 1'b1;
    inc = 16'h0000;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      chk("R6", t16, 1'b0, i);
      chk("R6", tbit, 1'b0, i);
    end
    // R6: switch from a live increment to zero and back, restart from zero
    run_case(16'hA5A5, 53, 1'b1);
    inc = 16'h0000;
    @(negedge clk);
    chk("R6", t16, 1'b0, 0);
    chk("R6", tbit, 1'b0, 0);
    run_case(16'hA5A5, 1500, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule